// File: doc/BRIEF.md
# Watchdog Timer with Delayed Reset Request

This block watches a small processor core for lost control. A free-running counter measures one of four periods, chosen by a 2-bit select input. When the period elapses, the block sets its interrupt flag. If reset generation is enabled, it then counts a fixed delay. At the end of that delay it requests a system reset, unless software restarts the watchdog or turns reset generation off first.

Software reaches the block through a byte-wide write/read port with two addresses: a control register and a key register. The bits that protect the system can only change after an unlock sequence written to the key register. The block also keeps sticky flags that record what caused the last reset: one for power-on and one for the watchdog. These flags survive every reset except power-on, so software can read them after a restart.

Two state machines run the block. The reset sequencer has the states WD_RUN, WD_ARMED and WD_FIRE:
- WD_RUN goes to WD_ARMED on a timeout while reset generation is enabled.
- WD_ARMED returns to WD_RUN on a restart or when reset generation is disabled.
- WD_ARMED goes to WD_FIRE when the delay count expires.
- WD_FIRE goes to WD_RUN after one cycle.

The unlock sequencer has the states UL_IDLE, UL_KEY1 and UL_OPEN:
- UL_IDLE goes to UL_KEY1 when 0xAA is written to the key register.
- UL_KEY1 goes to UL_OPEN when 0x55 is written to the key register in the next cycle. Anything else returns it to UL_IDLE; a repeated 0xAA keeps it in UL_KEY1.
- UL_OPEN goes to UL_IDLE on a control write or when its window runs out. A fresh 0xAA written to the key register moves it to UL_KEY1.

Top module: `wdt_core`

## Requirements
- R1: Register map. Address 0 is the control register and address 1 is the key register. Control register bits:
  - bit 0: reset enable
  - bit 1: restart
  - bit 2: interrupt flag
  - bit 3: watchdog-reset flag
  - bit 4: power-on flag
  - bits 7 to 5 read 0
- R2: After a restart, the interrupt flag is set 2^(6+2·mode_sel) clocks later, giving 64, 256, 1024 or 4096 clocks.
- R3: `irq` is high exactly when the interrupt flag is set and `irq_en` is high.
- R4: With reset enable set, `rst_req` goes high for one cycle exactly 512 clocks after the timeout. The watchdog-reset flag reads 1 from the following cycle.
- R5: A restart within the 512-clock window cancels the pending request, and so does clearing reset enable.
- R6: With reset enable clear, a timeout never raises `rst_req` and never sets the watchdog-reset flag.
- R7: Writing 0xAA and then 0x55 to the key register on consecutive cycles opens a window of 3 cycles. One control write inside the window is accepted as protected, and the window then closes. A key write sequence with a gap opens no window.
- R8: The reset-enable bit, the interrupt flag, the restart bit and the clearing of the power-on flag take effect only through a protected write. Ordinary control writes leave them unchanged.
- R9: A protected write of 1 to the interrupt flag sets it and raises `irq` when enabled. The flag stays set until it is cleared by software.
- R10: The watchdog-reset flag takes ordinary writes of 0 and 1, and writing 1 does not cause `rst_req`.
- R11: After power-on reset, the power-on flag reads 1 and the watchdog-reset flag reads 0. One cycle after release, reset enable equals `opt_rst_en`.
- R12: `soft_rst` clears the interrupt flag, the counters and the unlock state. It leaves reset enable, the power-on flag and the watchdog-reset flag unchanged.
- R13: `loader_entry` clears the power-on flag, the watchdog-reset flag and reset enable.
- R14: The restart bit always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| soft_rst | input | 1 | Synchronous reset from any other source, active high |
| wr_en | input | 1 | Register write strobe |
| addr | input | 1 | Register select: 0 for control, 1 for key |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Control register read value |
| mode_sel | input | 2 | Timeout period select |
| irq_en | input | 1 | Interrupt enable from the interrupt controller |
| opt_rst_en | input | 1 | Power-on default for reset enable |
| loader_entry | input | 1 | Loader entry pulse |
| irq | output | 1 | Watchdog interrupt request |
| rst_req | output | 1 | System reset request, one-cycle pulse |

## Verification
The bench measures each timeout and the reset delay to the exact clock. A counter or delay that is off by one shows up as a first-seen cycle count that differs from the expected value.

The unlock window is probed at its last open cycle and at the first closed cycle. A second write inside one window and a key sequence with a gap are both tried. A window that is one cycle too long, or that accepts more than one write, lets a protected bit change when it should not.

Both ways of cancelling a pending reset are tried: a restart, and clearing reset enable. A cancel that is ignored produces a `rst_req` pulse.

The sticky flags are checked across `soft_rst` and `loader_entry`. A design that treats every reset as power-on would lose those flags.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    typedef enum logic [1:0] {WD_RUN, WD_ARMED, WD_FIRE} wd_state_t;
    typedef enum logic [1:0] {UL_IDLE, UL_KEY1, UL_OPEN} ul_state_t;

    localparam int unsigned BIT_RST_EN  = 0;
    localparam int unsigned BIT_RESTART = 1;
    localparam int unsigned BIT_IRQF    = 2;
    localparam int unsigned BIT_WDRST   = 3;
    localparam int unsigned BIT_POR     = 4;

    localparam logic [7:0] KEY_FIRST  = 8'hAA;
    localparam logic [7:0] KEY_SECOND = 8'h55;
endpackage

// File: rtl/wdt_unlock.sv
module wdt_unlock
    import wdt_pkg::*;
#(
    parameter int unsigned WINDOW = 3
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       soft_rst,
    input  logic       key_wr,
    input  logic [7:0] key_data,
    input  logic       ctrl_wr,
    output logic       window_open
);
    localparam int unsigned WIN_W = $clog2(WINDOW + 1);

    ul_state_t        st_q, st_d;
    logic [WIN_W-1:0] win_q, win_d;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            st_q  <= UL_IDLE;
            win_q <= '0;
        end else if (soft_rst) begin
            st_q  <= UL_IDLE;
            win_q <= '0;
        end else begin
            st_q  <= st_d;
            win_q <= win_d;
        end
    end

    always_comb begin
        st_d  = st_q;
        win_d = win_q;
        unique case (st_q)
            UL_IDLE: begin
                if (key_wr && key_data == KEY_FIRST) st_d = UL_KEY1;
            end
            UL_KEY1: begin
                if (key_wr && key_data == KEY_SECOND) begin
                    st_d  = UL_OPEN;
                    win_d = '0;
                end else if (!(key_wr && key_data == KEY_FIRST)) begin
                    st_d = UL_IDLE;
                end
            end
            UL_OPEN: begin
                if (ctrl_wr) st_d = UL_IDLE;
                else if (key_wr && key_data == KEY_FIRST) st_d = UL_KEY1;
                else if (win_q == WIN_W'(WINDOW - 1)) st_d = UL_IDLE;
                else win_d = win_q + 1'b1;
            end
            default: st_d = UL_IDLE;
        endcase
    end

    always_comb begin
        window_open = (st_q == UL_OPEN);
    end
endmodule

// File: rtl/wdt_timebase.sv
module wdt_timebase #(
    parameter int unsigned BASE_LOG2 = 6,
    parameter int unsigned N_MODES   = 4
) (
    input  logic                       clk,
    input  logic                       por_n,
    input  logic                       clr,
    input  logic [$clog2(N_MODES)-1:0] mode,
    output logic                       timeout
);
    localparam int unsigned CNT_W = BASE_LOG2 + 2 * (N_MODES - 1);

    logic [CNT_W-1:0] lim [N_MODES];
    logic [CNT_W-1:0] cnt_q;

    for (genvar m = 0; m < N_MODES; m++) begin : g_lim
        assign lim[m] = CNT_W'((64'd1 << (BASE_LOG2 + 2 * m)) - 64'd1);
    end

    assign timeout = (cnt_q >= lim[mode]);

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)              cnt_q <= '0;
        else if (clr || timeout) cnt_q <= '0;
        else                     cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/wdt_reset_seq.sv
module wdt_reset_seq
    import wdt_pkg::*;
#(
    parameter int unsigned DELAY = 512
) (
    input  logic clk,
    input  logic por_n,
    input  logic soft_rst,
    input  logic timeout,
    input  logic rst_en,
    input  logic restart,
    output logic rst_req
);
    localparam int unsigned DLY_W = $clog2(DELAY);

    wd_state_t        st_q, st_d;
    logic [DLY_W-1:0] dly_q, dly_d;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            st_q  <= WD_RUN;
            dly_q <= '0;
        end else if (soft_rst) begin
            st_q  <= WD_RUN;
            dly_q <= '0;
        end else begin
            st_q  <= st_d;
            dly_q <= dly_d;
        end
    end

    always_comb begin
        st_d  = st_q;
        dly_d = dly_q;
        unique case (st_q)
            WD_RUN: begin
                if (timeout && rst_en && !restart) begin
                    st_d  = WD_ARMED;
                    dly_d = '0;
                end
            end
            WD_ARMED: begin
                if (restart || !rst_en) begin
                    st_d  = WD_RUN;
                    dly_d = '0;
                end else if (dly_q == DLY_W'(DELAY - 1)) begin
                    st_d = WD_FIRE;
                end else begin
                    dly_d = dly_q + 1'b1;
                end
            end
            WD_FIRE: begin
                st_d  = WD_RUN;
                dly_d = '0;
            end
            default: st_d = WD_RUN;
        endcase
    end

    always_comb begin
        rst_req = (st_q == WD_FIRE);
    end
endmodule

// File: rtl/wdt_core.sv
module wdt_core
    import wdt_pkg::*;
#(
    parameter int unsigned BASE_LOG2     = 6,
    parameter int unsigned RST_DELAY     = 512,
    parameter int unsigned UNLOCK_WINDOW = 3
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       soft_rst,
    input  logic       wr_en,
    input  logic       addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    input  logic [1:0] mode_sel,
    input  logic       irq_en,
    input  logic       opt_rst_en,
    input  logic       loader_entry,
    output logic       irq,
    output logic       rst_req
);
    localparam int unsigned N_MODES = 4;

    logic ctrl_wr, key_wr, window_open, timed_wr, restart, timeout;
    logic rst_en_q, irqf_q, wdrst_q, por_q, boot_q;

    assign ctrl_wr  = wr_en && (addr == 1'b0);
    assign key_wr   = wr_en && (addr == 1'b1);
    assign timed_wr = ctrl_wr && window_open;
    assign restart  = timed_wr && wdata[BIT_RESTART];

    wdt_unlock #(.WINDOW(UNLOCK_WINDOW)) unlock_i (
        .clk(clk), .por_n(por_n), .soft_rst(soft_rst), .key_wr(key_wr),
        .key_data(wdata), .ctrl_wr(ctrl_wr), .window_open(window_open)
    );

    wdt_timebase #(.BASE_LOG2(BASE_LOG2), .N_MODES(N_MODES)) timebase_i (
        .clk(clk), .por_n(por_n), .clr(soft_rst || restart || rst_req),
        .mode(mode_sel), .timeout(timeout)
    );

    wdt_reset_seq #(.DELAY(RST_DELAY)) seq_i (
        .clk(clk), .por_n(por_n), .soft_rst(soft_rst), .timeout(timeout),
        .rst_en(rst_en_q), .restart(restart), .rst_req(rst_req)
    );

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            boot_q   <= 1'b1;
            rst_en_q <= 1'b0;
            irqf_q   <= 1'b0;
            wdrst_q  <= 1'b0;
            por_q    <= 1'b1;
        end else begin
            boot_q <= 1'b0;

            if (soft_rst)      irqf_q <= 1'b0;
            else if (timeout)  irqf_q <= 1'b1;
            else if (timed_wr) irqf_q <= wdata[BIT_IRQF];

            if (loader_entry)  rst_en_q <= 1'b0;
            else if (boot_q)   rst_en_q <= opt_rst_en;
            else if (timed_wr) rst_en_q <= wdata[BIT_RST_EN];

            if (loader_entry)  wdrst_q <= 1'b0;
            else if (rst_req)  wdrst_q <= 1'b1;
            else if (ctrl_wr)  wdrst_q <= wdata[BIT_WDRST];

            if (loader_entry)                       por_q <= 1'b0;
            else if (timed_wr && !wdata[BIT_POR])   por_q <= 1'b0;
        end
    end

    always_comb begin
        rdata              = '0;
        rdata[BIT_RST_EN]  = rst_en_q;
        rdata[BIT_IRQF]    = irqf_q;
        rdata[BIT_WDRST]   = wdrst_q;
        rdata[BIT_POR]     = por_q;
        irq                = irqf_q && irq_en;
    end
endmodule

// File: rtl/wdt_core_chk.sv
module wdt_core_chk
    import wdt_pkg::*;
(
    input logic       clk,
    input logic       por_n,
    input logic       soft_rst,
    input logic       wr_en,
    input logic       addr,
    input logic [7:0] wdata,
    input logic       loader_entry,
    input logic [7:0] rdata,
    input logic       rst_req,
    input logic       window_open
);
    AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!por_n)
        rst_req |=> !rst_req); // R4

    AST_REQ_MARKS_CAUSE: assert property (@(posedge clk) disable iff (!por_n)
        rst_req && !loader_entry |=> rdata[BIT_WDRST]); // R4

    AST_REQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!por_n)
        rst_req |-> $past(rdata[BIT_RST_EN])); // R6

    AST_POR_NEVER_RISES: assert property (@(posedge clk) disable iff (!por_n)
        !rdata[BIT_POR] |=> !rdata[BIT_POR]); // R11

    AST_POR_GUARDED: assert property (@(posedge clk) disable iff (!por_n)
        wr_en && !addr && !window_open && !loader_entry |=> $stable(rdata[BIT_POR])); // R8

    AST_WDRST_STICKY: assert property (@(posedge clk) disable iff (!por_n)
        soft_rst && !wr_en && !loader_entry && !rst_req |=> $stable(rdata[BIT_WDRST])); // R12

    AST_WINDOW_SINGLE_USE: assert property (@(posedge clk) disable iff (!por_n)
        window_open && wr_en && !addr |=> !window_open); // R7

    AST_WINDOW_NEEDS_KEY: assert property (@(posedge clk) disable iff (!por_n)
        $rose(window_open) |-> $past(wr_en && addr && wdata == KEY_SECOND)); // R7
endmodule

bind wdt_core wdt_core_chk chk_i (
    .clk(clk), .por_n(por_n), .soft_rst(soft_rst), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .loader_entry(loader_entry),
    .rdata(rdata), .rst_req(rst_req), .window_open(window_open)
);

// File: tb/wdt_core_tb_top.sv
`timescale 1ns/1ps
module wdt_core_tb_top;
    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       soft_rst = 1'b0;
    logic       wr_en = 1'b0;
    logic       addr = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic [1:0] mode_sel = 2'd3;
    logic       irq_en = 1'b1;
    logic       opt_rst_en = 1'b0;
    logic       loader_entry = 1'b0;
    logic       irq, rst_req;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    wdt_core dut_i (
        .clk(clk), .por_n(por_n), .soft_rst(soft_rst), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .mode_sel(mode_sel),
        .irq_en(irq_en), .opt_rst_en(opt_rst_en), .loader_entry(loader_entry),
        .irq(irq), .rst_req(rst_req)
    );

    task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
        end
    endtask

    task automatic do_por(input logic opt);
        @(negedge clk);
        opt_rst_en = opt;
        por_n = 1'b0;
        repeat (2) @(negedge clk);
        por_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = 8'h00;
    endtask

    task automatic tw(input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; addr = 1'b1; wdata = 8'hAA;
        @(negedge clk); wdata = 8'h55;
        @(negedge clk); addr = 1'b0; wdata = d;
        @(negedge clk); wr_en = 1'b0; wdata = 8'h00;
    endtask

    task automatic t_reset_state();
        do_por(1'b0);
        chk("R11", "rdata after por", 32'(rdata), 32'h10);
        chk("R11", "rst_req after por", 32'(rst_req), 32'h0);
        chk("R3", "irq after por", 32'(irq), 32'h0);
    endtask

    task automatic t_protect();
        wr(1'b0, 8'h07);
        chk("R8", "ordinary write to protected bits", 32'(rdata), 32'h10);
        wr(1'b0, 8'h00);
        chk("R8", "ordinary write cannot clear por flag", 32'(rdata), 32'h10);
        @(negedge clk); wr_en = 1'b1; addr = 1'b1; wdata = 8'hAA;
        @(negedge clk); wr_en = 1'b0;
        @(negedge clk); wr_en = 1'b1; wdata = 8'h55;
        @(negedge clk); addr = 1'b0; wdata = 8'h13;
        @(negedge clk); wr_en = 1'b0; wdata = 8'h00;
        chk("R7", "gapped key sequence opens no window", 32'(rdata), 32'h10);
    endtask

    task automatic t_soft_rst();
        tw(8'h17);
        chk("R14", "restart bit reads zero", 32'(rdata[1]), 32'h0);
        wr(1'b0, 8'h08);
        chk("R1", "flags set before soft reset", 32'(rdata), 32'h1D);
        @(negedge clk); soft_rst = 1'b1;
        @(negedge clk); soft_rst = 1'b0;
        chk("R12", "soft reset keeps sticky bits, clears irq flag", 32'(rdata), 32'h19);
    endtask

    task automatic t_loader();
        @(negedge clk); loader_entry = 1'b1;
        @(negedge clk); loader_entry = 1'b0;
        chk("R13", "loader entry clears por, wdrst, rst_en", 32'(rdata), 32'h00);
    endtask

    task automatic t_default_on();
        do_por(1'b1);
        chk("R11", "reset enable loads option input", 32'(rdata), 32'h11);
        tw(8'h02);
        chk("R8", "protected write clears por flag and rst_en", 32'(rdata), 32'h00);
    endtask

    task automatic t_window();
        @(negedge clk); wr_en = 1'b1; addr = 1'b1; wdata = 8'hAA;
        @(negedge clk); wdata = 8'h55;
        @(negedge clk); wr_en = 1'b0;
        @(negedge clk);
        @(negedge clk); wr_en = 1'b1; addr = 1'b0; wdata = 8'h03;
        @(negedge clk); wr_en = 1'b0;
        chk("R7", "write in last window cycle accepted", 32'(rdata[0]), 32'h1);
        tw(8'h02);
        @(negedge clk); wr_en = 1'b1; addr = 1'b1; wdata = 8'hAA;
        @(negedge clk); wdata = 8'h55;
        @(negedge clk); wr_en = 1'b0;
        repeat (2) @(negedge clk);
        @(negedge clk); wr_en = 1'b1; addr = 1'b0; wdata = 8'h03;
        @(negedge clk); wr_en = 1'b0;
        chk("R7", "write after window closed ignored", 32'(rdata[0]), 32'h0);
        @(negedge clk); wr_en = 1'b1; addr = 1'b1; wdata = 8'hAA;
        @(negedge clk); wdata = 8'h55;
        @(negedge clk); addr = 1'b0; wdata = 8'h02;
        @(negedge clk); wdata = 8'h03;
        @(negedge clk); wr_en = 1'b0;
        chk("R7", "second write in one window ignored", 32'(rdata[0]), 32'h0);
    endtask

    task automatic t_period(input logic [1:0] m);
        int first = 0;
        mode_sel = m;
        irq_en = 1'b1;
        tw(8'h02);
        for (int k = 1; k <= 5000; k++) begin
            @(negedge clk);
            if (rdata[2]) begin first = k; break; end
        end
        chk("R2", $sformatf("timeout period mode %0d", m), 32'(first), 32'(1 << (6 + 2 * m)));
        chk("R3", "irq follows flag when enabled", 32'(irq), 32'h1);
        irq_en = 1'b0;
        @(negedge clk);
        chk("R3", "irq low when disabled", 32'(irq), 32'h0);
        irq_en = 1'b1;
        mode_sel = 2'd3;
        tw(8'h02);
    endtask

    task automatic t_delay();
        int first_irq = 0;
        int first_req = 0;
        mode_sel = 2'd0;
        tw(8'h03);
        for (int k = 1; k <= 800; k++) begin
            @(negedge clk);
            if (rdata[2] && first_irq == 0) first_irq = k;
            if (rst_req) begin first_req = k; break; end
        end
        chk("R4", "reset request 512 clocks after timeout", 32'(first_req - first_irq), 32'd512);
        @(negedge clk);
        chk("R4", "reset request is one cycle", 32'(rst_req), 32'h0);
        chk("R4", "watchdog-reset flag set", 32'(rdata[3]), 32'h1);
        tw(8'h0A);
        wr(1'b0, 8'h00);
        chk("R10", "watchdog-reset flag cleared by write", 32'(rdata[3]), 32'h0);
    endtask

    task automatic t_cancel_restart();
        int seen = 0;
        mode_sel = 2'd0;
        tw(8'h03);
        repeat (300) @(negedge clk);
        tw(8'h03);
        for (int k = 0; k < 500; k++) begin
            @(negedge clk);
            if (rst_req) seen = 1;
        end
        chk("R5", "restart cancels pending request", 32'(seen), 32'h0);
        tw(8'h02);
    endtask

    task automatic t_cancel_disable();
        int seen = 0;
        mode_sel = 2'd0;
        tw(8'h03);
        repeat (300) @(negedge clk);
        tw(8'h04);
        for (int k = 0; k < 700; k++) begin
            @(negedge clk);
            if (rst_req) seen = 1;
        end
        chk("R5", "clearing enable cancels request", 32'(seen), 32'h0);
        chk("R6", "no watchdog-reset flag while disabled", 32'(rdata[3]), 32'h0);
        mode_sel = 2'd3;
        tw(8'h02);
    endtask

    task automatic t_wdrst_sw();
        int seen = 0;
        wr(1'b0, 8'h08);
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (rst_req) seen = 1;
        end
        chk("R10", "software set of watchdog-reset flag", 32'(rdata[3]), 32'h1);
        chk("R10", "setting flag does not request reset", 32'(seen), 32'h0);
        wr(1'b0, 8'h00);
    endtask

    task automatic t_sw_irq();
        irq_en = 1'b1;
        tw(8'h06);
        repeat (10) @(negedge clk);
        chk("R9", "software-set flag raises irq and holds", 32'(irq), 32'h1);
        tw(8'h02);
        chk("R9", "software clear drops irq", 32'(irq), 32'h0);
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog: run did not finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset_state();
        t_protect();
        t_soft_rst();
        t_loader();
        t_default_on();
        t_window();
        t_period(2'd0);
        t_period(2'd1);
        t_period(2'd2);
        t_delay();
        t_cancel_restart();
        t_cancel_disable();
        t_wdrst_sw();
        t_sw_irq();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule